// File: doc/BRIEF.md
# Operand Descriptor Stream Decoder

This block turns a byte-serial instruction stream into one decoded operand at a time. Bytes arrive one per cycle under a valid/ready handshake. In descriptor mode the first byte is split into a mode nibble (bits 7:4) and a register nibble (bits 3:0). The pair selects an operand class. The class may call for trailing bytes that carry an immediate, a displacement or an absolute address, and those bytes arrive least-significant first. Once the last byte is taken, the block issues a one-cycle result record. The record holds the class code, the register nibble, the embedded value widened to 32 bits, the operand length in bytes, an expanded-type marker with its type nibble, and an illegal flag.

The meaning of a mode depends on the register nibble. Register 15 turns the register-based modes into immediate or absolute forms, and register 11 is not allowed as a base register. A mode-14 descriptor with a register below 15 is a type-override prefix, and a full second descriptor follows it. A separate branch mode, chosen with the first byte, reads the stream as a bare signed 8-bit or 16-bit displacement with no descriptor. The context inputs (branch mode, branch width, destination use and address-required use) are sampled only with the first byte of an operand.

Top module: `opd_decoder`

## Requirements
- R1: During reset res_valid is 0. One cycle after reset is released, in_ready is 1, and it stays 1.
- R2: Mode 0..3 with any register is a positive literal, class 0, with value equal to the descriptor byte zero-extended. Mode 15 is a negative literal, class 1, with value equal to the descriptor byte sign-extended. Both are 1 byte long.
- R3: With register 0..14, mode 4 is register direct (class 2, value 0), mode 5 is register deferred (class 3, value 0), mode 6 is a frame-pointer short offset (class 4) and mode 7 is an argument-pointer short offset (class 5). Both offset classes carry the register nibble as their value. All four are 1 byte long.
- R4: With register 15, mode 6 is a byte immediate (class 6, length 2), mode 5 a halfword immediate (class 7, length 3) and mode 4 a word immediate (class 8, length 5). Trailing bytes are taken LSB first, and byte and halfword values are sign-extended.
- R5: With register 15, mode 7 is absolute (class 9) and mode 14 is absolute deferred (class 10). Each takes a 4-byte address, LSB first, for a length of 5.
- R6: Displacement modes: 12/13 are byte plain/deferred (classes 11/12, length 2), 10/11 are halfword (classes 13/14, length 3) and 8/9 are word (classes 15/16, length 5). Byte and halfword displacements are sign-extended, and res_reg reports the base register.
- R7: Mode 14 with register 0..14 is a prefix. The next byte is decoded as a descriptor, res_ext is 1, res_xtype is the prefix's register nibble and the length is one more than the second descriptor's own length. Without a prefix, res_ext and res_xtype are 0.
- R8: When ctx_branch is 1 on the first byte, no descriptor is read. With ctx_branch16=0 the byte is a signed displacement (class 17, length 1). With ctx_branch16=1 two bytes, low first, form a signed displacement (class 18, length 2). res_reg is 0.
- R9: res_illegal is 1 for a literal or immediate when ctx_dest or ctx_ea was 1 on the first byte, and for register direct when ctx_ea was 1. Across a prefix, the context from the prefix byte applies.
- R10: res_illegal is 1 for a displacement mode or mode 5 with register 11, and for a prefix followed by a second prefix. The second prefix reports class 19, length 2, value 0. All bytes of an illegal operand are still consumed and the result is still reported.
- R11: The result appears in the cycle after the operand's last byte is accepted. The first byte of the next operand can be accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte is valid |
| in_byte | input | 8 | Stream byte |
| ctx_branch | input | 1 | First byte starts a descriptorless branch displacement |
| ctx_branch16 | input | 1 | Branch displacement is 16 bits (else 8) |
| ctx_dest | input | 1 | Operand is a destination |
| ctx_ea | input | 1 | Operand's effective address is required |
| in_ready | output | 1 | Block accepts a byte this cycle |
| res_valid | output | 1 | Result record valid (one cycle) |
| res_class | output | 5 | Operand class code |
| res_reg | output | 4 | Register nibble of the final descriptor |
| res_value | output | 32 | Embedded value, extended to 32 bits |
| res_len | output | 3 | Operand length in bytes |
| res_ext | output | 1 | Type-override prefix was present |
| res_xtype | output | 4 | Type nibble from the prefix |
| res_illegal | output | 1 | Operand is illegal in its context |

## Verification
The overlap of interest is between issuing a result and accepting the first byte of the next operand, which happen in the same cycle. The bench feeds operands back to back with no idle cycle, including runs of single-byte literals that produce a result on every cycle, and mixes in idle gaps elsewhere. The scoreboard requires each result exactly one cycle after its last byte. An illegal or nested-prefix operand is followed at once by a normal one, so a lost or duplicated byte would show up as a wrong class or value in the next record.

// File: rtl/opd_pkg.sv
package opd_pkg;
  typedef enum logic [4:0] {
    C_POSLIT = 5'd0,  C_NEGLIT = 5'd1,  C_REG    = 5'd2,  C_REGDEF = 5'd3,
    C_FPOFF  = 5'd4,  C_APOFF  = 5'd5,  C_IMM8   = 5'd6,  C_IMM16  = 5'd7,
    C_IMM32  = 5'd8,  C_ABS    = 5'd9,  C_ABSDEF = 5'd10, C_DSP8   = 5'd11,
    C_DSP8D  = 5'd12, C_DSP16  = 5'd13, C_DSP16D = 5'd14, C_DSP32  = 5'd15,
    C_DSP32D = 5'd16, C_BR8    = 5'd17, C_BR16   = 5'd18, C_XNEST  = 5'd19
  } opd_cls_e;

  localparam int TAIL_CNT_W = 3;
endpackage

// File: rtl/opd_classify.sv
module opd_classify
  import opd_pkg::*;
(
  input  logic [3:0]            mode,
  input  logic [3:0]            regn,
  input  logic                  dest,
  input  logic                  ea,
  output opd_cls_e              cls,
  output logic [TAIL_CNT_W-1:0] tail,
  output logic                  sext,
  output logic                  prefix,
  output logic                  ill
);
  logic r15, r11, no_imm;
  assign r15    = (regn == 4'hF);
  assign r11    = (regn == 4'hB);
  assign no_imm = dest | ea;

  always_comb begin
    cls    = C_REG;
    tail   = '0;
    sext   = 1'b0;
    prefix = 1'b0;
    ill    = 1'b0;
    case (mode)
      4'd0, 4'd1, 4'd2, 4'd3: begin cls = C_POSLIT; ill = no_imm; end
      4'd15:                  begin cls = C_NEGLIT; ill = no_imm; end
      4'd4: begin
        if (r15) begin cls = C_IMM32; tail = 3'd4; ill = no_imm; end
        else     begin cls = C_REG;   ill = ea; end
      end
      4'd5: begin
        if (r15) begin cls = C_IMM16; tail = 3'd2; sext = 1'b1; ill = no_imm; end
        else     begin cls = C_REGDEF; ill = r11; end
      end
      4'd6: begin
        if (r15) begin cls = C_IMM8; tail = 3'd1; sext = 1'b1; ill = no_imm; end
        else     cls = C_FPOFF;
      end
      4'd7: begin
        if (r15) begin cls = C_ABS; tail = 3'd4; end
        else     cls = C_APOFF;
      end
      4'd8:  begin cls = C_DSP32;  tail = 3'd4; ill = r11; end
      4'd9:  begin cls = C_DSP32D; tail = 3'd4; ill = r11; end
      4'd10: begin cls = C_DSP16;  tail = 3'd2; sext = 1'b1; ill = r11; end
      4'd11: begin cls = C_DSP16D; tail = 3'd2; sext = 1'b1; ill = r11; end
      4'd12: begin cls = C_DSP8;   tail = 3'd1; sext = 1'b1; ill = r11; end
      4'd13: begin cls = C_DSP8D;  tail = 3'd1; sext = 1'b1; ill = r11; end
      default: begin
        if (r15) begin cls = C_ABSDEF; tail = 3'd4; end
        else     begin cls = C_XNEST; prefix = 1'b1; end
      end
    endcase
  end
endmodule

// File: rtl/opd_gather.sv
module opd_gather #(
  parameter int VAL_W = 32,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ld,
  input  logic [7:0]       din,
  output logic [CNT_W-1:0] cnt,
  output logic [VAL_W-1:0] acc_nx
);
  logic [VAL_W-1:0] acc_q;

  assign acc_nx = acc_q | (VAL_W'(din) << (8 * cnt));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
      cnt   <= '0;
    end else if (ld) begin
      acc_q <= acc_nx;
      cnt   <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/opd_decoder.sv
module opd_decoder
  import opd_pkg::*;
#(
  parameter int VAL_W = 32,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             ctx_branch,
  input  logic             ctx_branch16,
  input  logic             ctx_dest,
  input  logic             ctx_ea,
  output logic             in_ready,
  output logic             res_valid,
  output logic [4:0]       res_class,
  output logic [3:0]       res_reg,
  output logic [VAL_W-1:0] res_value,
  output logic [LEN_W-1:0] res_len,
  output logic             res_ext,
  output logic [3:0]       res_xtype,
  output logic             res_illegal
);
  localparam int CNT_W = TAIL_CNT_W;

  typedef enum logic {S_DESC, S_TAIL} st_e;

  st_e              st_q;
  logic             xt_q, dest_q, ea_q, sext_q, ill_q;
  logic [3:0]       xtype_q, reg_q;
  logic [CNT_W-1:0] need_q;
  logic [LEN_W-1:0] base_q;
  opd_cls_e         cls_q;

  logic             accept, first, c_dest, c_ea, is_branch, tail_done, g_ld, fin;
  opd_cls_e         k_cls;
  logic [CNT_W-1:0] k_tail, g_cnt;
  logic             k_sext, k_pre, k_ill;
  logic [VAL_W-1:0] g_acc, one_val, tail_val;
  logic [LEN_W-1:0] base_now;

  assign accept    = in_valid & in_ready;
  assign first     = (st_q == S_DESC) & ~xt_q;
  assign c_dest    = first ? ctx_dest : dest_q;
  assign c_ea      = first ? ctx_ea : ea_q;
  assign is_branch = first & ctx_branch;
  assign base_now  = xt_q ? LEN_W'(1) : LEN_W'(0);

  opd_classify u_cls (
    .mode(in_byte[7:4]), .regn(in_byte[3:0]), .dest(c_dest), .ea(c_ea),
    .cls(k_cls), .tail(k_tail), .sext(k_sext), .prefix(k_pre), .ill(k_ill)
  );

  assign tail_done = (st_q == S_TAIL) & ((g_cnt + CNT_W'(1)) == need_q);
  assign g_ld      = accept & ((st_q == S_TAIL) | (is_branch & ctx_branch16));
  assign fin       = accept & ((st_q == S_TAIL) ? tail_done :
                     (is_branch ? ~ctx_branch16 : (k_pre ? xt_q : (k_tail == '0))));

  opd_gather #(.VAL_W(VAL_W), .CNT_W(CNT_W)) u_gat (
    .clk(clk), .rst(rst), .clr(fin), .ld(g_ld), .din(in_byte),
    .cnt(g_cnt), .acc_nx(g_acc)
  );

  always_comb begin
    case (k_cls)
      C_POSLIT:        one_val = VAL_W'(in_byte);
      C_NEGLIT:        one_val = {{(VAL_W-8){in_byte[7]}}, in_byte};
      C_FPOFF, C_APOFF: one_val = VAL_W'(in_byte[3:0]);
      default:         one_val = '0;
    endcase
  end

  always_comb begin
    tail_val = g_acc;
    if (sext_q) begin
      if (need_q == CNT_W'(1))      tail_val = {{(VAL_W-8){g_acc[7]}}, g_acc[7:0]};
      else if (need_q == CNT_W'(2)) tail_val = {{(VAL_W-16){g_acc[15]}}, g_acc[15:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= S_DESC; in_ready <= 1'b0; res_valid <= 1'b0;
      xt_q <= 1'b0; dest_q <= 1'b0; ea_q <= 1'b0; sext_q <= 1'b0; ill_q <= 1'b0;
      xtype_q <= '0; reg_q <= '0; need_q <= '0; base_q <= '0; cls_q <= C_POSLIT;
      res_class <= '0; res_reg <= '0; res_value <= '0; res_len <= '0;
      res_ext <= 1'b0; res_xtype <= '0; res_illegal <= 1'b0;
    end else begin
      in_ready  <= 1'b1;
      res_valid <= 1'b0;
      if (accept) begin
        if (st_q == S_DESC) begin
          if (is_branch) begin
            if (ctx_branch16) begin
              cls_q <= C_BR16; need_q <= CNT_W'(2); sext_q <= 1'b1; ill_q <= 1'b0;
              reg_q <= '0; base_q <= '0; st_q <= S_TAIL;
            end else begin
              res_valid <= 1'b1; res_class <= C_BR8; res_reg <= '0;
              res_value <= {{(VAL_W-8){in_byte[7]}}, in_byte};
              res_len <= LEN_W'(1); res_ext <= 1'b0; res_xtype <= '0; res_illegal <= 1'b0;
            end
          end else if (k_pre) begin
            if (xt_q) begin
              res_valid <= 1'b1; res_class <= C_XNEST; res_reg <= in_byte[3:0];
              res_value <= '0; res_len <= LEN_W'(2); res_ext <= 1'b1;
              res_xtype <= xtype_q; res_illegal <= 1'b1; xt_q <= 1'b0;
            end else begin
              xt_q <= 1'b1; xtype_q <= in_byte[3:0];
              dest_q <= ctx_dest; ea_q <= ctx_ea;
            end
          end else if (k_tail == '0) begin
            res_valid <= 1'b1; res_class <= k_cls; res_reg <= in_byte[3:0];
            res_value <= one_val; res_len <= base_now + LEN_W'(1);
            res_ext <= xt_q; res_xtype <= xt_q ? xtype_q : 4'd0;
            res_illegal <= k_ill; xt_q <= 1'b0;
          end else begin
            cls_q <= k_cls; need_q <= k_tail; sext_q <= k_sext; ill_q <= k_ill;
            reg_q <= in_byte[3:0]; base_q <= base_now + LEN_W'(1); st_q <= S_TAIL;
          end
        end else if (tail_done) begin
          res_valid <= 1'b1; res_class <= cls_q; res_reg <= reg_q;
          res_value <= tail_val; res_len <= base_q + LEN_W'(need_q);
          res_ext <= xt_q; res_xtype <= xt_q ? xtype_q : 4'd0;
          res_illegal <= ill_q; xt_q <= 1'b0; st_q <= S_DESC;
        end
      end
    end
  end
endmodule

// File: rtl/opd_decoder_chk.sv
module opd_decoder_chk
  import opd_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        in_ready,
  input logic        res_valid,
  input logic [4:0]  res_class,
  input logic [31:0] res_value,
  input logic [2:0]  res_len,
  input logic        res_ext,
  input logic [3:0]  res_xtype,
  input logic        res_illegal
);
  p_poslit_r2: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_class == C_POSLIT) |-> (res_value[31:8] == 24'd0 && res_len == 3'd1 + 3'(res_ext)));

  p_neglit_r2: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_class == C_NEGLIT) |-> (res_value[31:7] == {25{1'b1}}));

  p_imm8_sext_r4: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_class == C_IMM8) |-> (res_value[31:8] == {24{res_value[7]}} && res_len == 3'd2 + 3'(res_ext)));

  p_noext_xtype_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ext) |-> (res_xtype == 4'd0));

  p_br8_r8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_class == C_BR8) |-> (res_len == 3'd1 && !res_ext && !res_illegal));

  p_nest_r10: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_class == C_XNEST) |-> (res_illegal && res_ext && res_len == 3'd2));

  p_ready_r11: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> in_ready);
endmodule

bind opd_decoder opd_decoder_chk chk_i (
  .clk(clk), .rst(rst), .in_ready(in_ready), .res_valid(res_valid),
  .res_class(res_class), .res_value(res_value), .res_len(res_len),
  .res_ext(res_ext), .res_xtype(res_xtype), .res_illegal(res_illegal)
);

// File: tb/opd_decoder_tb_top.sv
module opd_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        ctx_branch = 1'b0, ctx_branch16 = 1'b0, ctx_dest = 1'b0, ctx_ea = 1'b0;
  logic        in_ready, res_valid, res_ext, res_illegal;
  logic [4:0]  res_class;
  logic [3:0]  res_reg, res_xtype;
  logic [31:0] res_value;
  logic [2:0]  res_len;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    string       rq;
    logic [4:0]  cls;
    logic [3:0]  rg;
    logic [31:0] val;
    logic [2:0]  len;
    logic        ext;
    logic [3:0]  xt;
    logic        ill;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  opd_decoder dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .ctx_branch(ctx_branch), .ctx_branch16(ctx_branch16), .ctx_dest(ctx_dest), .ctx_ea(ctx_ea),
    .in_ready(in_ready), .res_valid(res_valid), .res_class(res_class), .res_reg(res_reg),
    .res_value(res_value), .res_len(res_len), .res_ext(res_ext), .res_xtype(res_xtype),
    .res_illegal(res_illegal)
  );

  task automatic send(input string rq, input int n, input logic [47:0] b,
                      input logic br, input logic br16, input logic dst, input logic ea,
                      input logic [4:0] cls, input logic [3:0] rg, input logic [31:0] val,
                      input logic [2:0] len, input logic ext, input logic [3:0] xt, input logic ill);
    exp_t e;
    e.rq = rq; e.cls = cls; e.rg = rg; e.val = val; e.len = len; e.ext = ext; e.xt = xt; e.ill = ill;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid     = 1'b1;
      in_byte      = b[8*i +: 8];
      ctx_branch   = (i == 0) ? br : 1'b0;
      ctx_branch16 = (i == 0) ? br16 : 1'b0;
      ctx_dest     = (i == 0) ? dst : 1'b0;
      ctx_ea       = (i == 0) ? ea : 1'b0;
      @(posedge clk);
      if (i == n - 1) sb.push_back(e);
    end
  endtask

  task automatic idle(input int k);
    @(negedge clk);
    in_valid = 1'b0; ctx_branch = 1'b0; ctx_branch16 = 1'b0; ctx_dest = 1'b0; ctx_ea = 1'b0;
    repeat (k) @(negedge clk);
  endtask

  // Scoreboard monitor: each expected record must appear one cycle after its last byte (R11)
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (!res_valid) begin
          fails++;
          $display("FAIL %s R11 latency: res_valid=%0b expected 1", e.rq, res_valid);
        end else if (res_class !== e.cls || res_reg !== e.rg || res_value !== e.val ||
                     res_len !== e.len || res_ext !== e.ext || res_xtype !== e.xt ||
                     res_illegal !== e.ill || in_ready !== 1'b1) begin
          fails++;
          $display("FAIL %s actual cls=%0d reg=%0d val=%h len=%0d ext=%0b xt=%0d ill=%0b rdy=%0b expected cls=%0d reg=%0d val=%h len=%0d ext=%0b xt=%0d ill=%0b rdy=1",
                   e.rq, res_class, res_reg, res_value, res_len, res_ext, res_xtype, res_illegal, in_ready,
                   e.cls, e.rg, e.val, e.len, e.ext, e.xt, e.ill);
        end
      end else if (res_valid) begin
        checks++; fails++;
        $display("FAIL R11 unexpected result: res_valid=1 expected 0");
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (res_valid !== 1'b0) begin fails++; $display("FAIL R1 reset res_valid=%0b expected 0", res_valid); end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (in_ready !== 1'b1) begin fails++; $display("FAIL R1 in_ready=%0b expected 1", in_ready); end

    // R2 literals, back to back (result and next first byte share cycles: R11)
    send("R2 poslit",  1, 48'h2A, 0,0,0,0, 5'd0, 4'hA, 32'h0000002A, 3'd1, 0, 4'd0, 0);
    send("R2 neglit",  1, 48'hF3, 0,0,0,0, 5'd1, 4'h3, 32'hFFFFFFF3, 3'd1, 0, 4'd0, 0);
    // R3 register forms
    send("R3 reg",     1, 48'h41, 0,0,0,0, 5'd2, 4'h1, 32'h0, 3'd1, 0, 4'd0, 0);
    send("R3 regdef",  1, 48'h52, 0,0,0,0, 5'd3, 4'h2, 32'h0, 3'd1, 0, 4'd0, 0);
    send("R3 fpoff",   1, 48'h69, 0,0,0,0, 5'd4, 4'h9, 32'h9, 3'd1, 0, 4'd0, 0);
    send("R3 apoff",   1, 48'h7C, 0,0,0,0, 5'd5, 4'hC, 32'hC, 3'd1, 0, 4'd0, 0);
    idle(2);
    // R4 immediates
    send("R4 imm8",    2, 48'h806F, 0,0,0,0, 5'd6, 4'hF, 32'hFFFFFF80, 3'd2, 0, 4'd0, 0);
    send("R4 imm16",   3, 48'h92345F, 0,0,0,0, 5'd7, 4'hF, 32'hFFFF9234, 3'd3, 0, 4'd0, 0);
    send("R4 imm32",   5, 48'h123456784F, 0,0,0,0, 5'd8, 4'hF, 32'h12345678, 3'd5, 0, 4'd0, 0);
    // R5 absolute
    send("R5 abs",     5, 48'hDEADBEEF7F, 0,0,0,0, 5'd9, 4'hF, 32'hDEADBEEF, 3'd5, 0, 4'd0, 0);
    send("R5 absdef",  5, 48'h04030201EF, 0,0,0,0, 5'd10, 4'hF, 32'h04030201, 3'd5, 0, 4'd0, 0);
    idle(1);
    // R6 displacements
    send("R6 dsp8",    2, 48'h06C1, 0,0,0,0, 5'd11, 4'h1, 32'h6, 3'd2, 0, 4'd0, 0);
    send("R6 dsp8d",   2, 48'hFED3, 0,0,0,0, 5'd12, 4'h3, 32'hFFFFFFFE, 3'd2, 0, 4'd0, 0);
    send("R6 dsp16",   3, 48'h8000A5, 0,0,0,0, 5'd13, 4'h5, 32'hFFFF8000, 3'd3, 0, 4'd0, 0);
    send("R6 dsp16d",  3, 48'h7FFFB0, 0,0,0,0, 5'd14, 4'h0, 32'h00007FFF, 3'd3, 0, 4'd0, 0);
    send("R6 dsp32",   5, 48'h443322118F, 0,0,0,0, 5'd15, 4'hF, 32'h44332211, 3'd5, 0, 4'd0, 0);
    send("R6 dsp32d",  5, 48'h800000019E, 0,0,0,0, 5'd16, 4'hE, 32'h80000001, 3'd5, 0, 4'd0, 0);
    // R7 expanded-type prefix
    send("R7 ext imm8", 3, 48'h056FE3, 0,0,0,0, 5'd6, 4'hF, 32'h5, 3'd3, 1, 4'd3, 0);
    send("R7 ext imm32", 6, 48'hCAFEF00D4FE7, 0,0,0,0, 5'd8, 4'hF, 32'hCAFEF00D, 3'd6, 1, 4'd7, 0);
    send("R7 ext reg", 2, 48'h41E2, 0,0,0,0, 5'd2, 4'h1, 32'h0, 3'd2, 1, 4'd2, 0);
    idle(3);
    // R8 branch displacements
    send("R8 br8",     1, 48'h90, 1,0,0,0, 5'd17, 4'h0, 32'hFFFFFF90, 3'd1, 0, 4'd0, 0);
    send("R8 br16",    2, 48'h01FF, 1,1,0,0, 5'd18, 4'h0, 32'h000001FF, 3'd2, 0, 4'd0, 0);
    send("R8 br16neg", 2, 48'h8000, 1,1,0,0, 5'd18, 4'h0, 32'hFFFF8000, 3'd2, 0, 4'd0, 0);
    // R9 context-dependent illegality
    send("R9 lit dest", 1, 48'h05, 0,0,1,0, 5'd0, 4'h5, 32'h5, 3'd1, 0, 4'd0, 1);
    send("R9 imm8 ea", 2, 48'h016F, 0,0,0,1, 5'd6, 4'hF, 32'h1, 3'd2, 0, 4'd0, 1);
    send("R9 reg ea",  1, 48'h43, 0,0,0,1, 5'd2, 4'h3, 32'h0, 3'd1, 0, 4'd0, 1);
    send("R9 reg dest ok", 1, 48'h43, 0,0,1,0, 5'd2, 4'h3, 32'h0, 3'd1, 0, 4'd0, 0);
    send("R9 ext lit dest", 2, 48'h0FE1, 0,0,1,0, 5'd0, 4'hF, 32'hF, 3'd2, 1, 4'd1, 1);
    // R10 register 11 and nested prefix, bytes consumed
    send("R10 dsp r11", 2, 48'h10CB, 0,0,0,0, 5'd11, 4'hB, 32'h10, 3'd2, 0, 4'd0, 1);
    send("R10 regdef r11", 1, 48'h5B, 0,0,0,0, 5'd3, 4'hB, 32'h0, 3'd1, 0, 4'd0, 1);
    send("R10 nested", 2, 48'hE2E1, 0,0,0,0, 5'd19, 4'h2, 32'h0, 3'd2, 1, 4'd1, 1);
    send("R10 after nested", 1, 48'h2A, 0,0,0,0, 5'd0, 4'hA, 32'h2A, 3'd1, 0, 4'd0, 0);
    idle(4);

    done = 1'b1;
    if (sb.size() != 0) begin
      checks++; fails++;
      $display("FAIL R11 missing results: %0d pending expected 0", sb.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule